// File: doc/BRIEF.md
# UART receive buffer with timeout and DMA requests

This block sits behind a UART deserializer. It holds received characters until software or a DMA engine collects them. Each character is stored as 12 bits: eight data bits and four line-error flags. The buffer drives two DMA request lines:

- a single-character request, asserted while anything is buffered;
- a burst request, asserted while the fill level is above a programmable watermark.

It also raises three interrupt causes:

- a fill-level interrupt;
- a receive-timeout interrupt, raised after 32 bit periods of silence while characters are still waiting;
- an overrun interrupt, raised when a character arrives while the buffer is full.

The character input is a valid/ready stream. `in_ready` is high whenever the buffer has room. The deserializer cannot stall the line, so it may present `in_valid` while `in_ready` is low. In that case the character is discarded and the overrun flag is set; there is no back-pressure beyond that.

Software uses a small register port with combinational read data. A read of the data register removes the head character. Because the timeout counts only while data sits in the buffer, a DMA engine that drains on single requests empties the buffer and no timeout follows.

Top module: `uart_rx_buffer`

## Requirements
- R1: Reads of register address 0 return the oldest buffered character as bits [11:8] = error flags and bits [7:0] = data, and remove it, so characters come out in arrival order.
- R2: `in_ready` is low exactly when 32 characters are held. A character offered while `in_ready` is low is discarded, and status bit 2 (overrun) becomes 1 until software writes 1 to bit 2 of the clear register (address 5).
- R3: `dma_single` is high exactly when at least one character is held.
- R4: `dma_burst` is high exactly when the fill level exceeds the watermark. The watermark is selected by register address 1, bits [2:0]: 0 gives 4, 1 gives 8, 2 gives 16, 3 gives 24, 4 gives 28, and 5 to 7 give 16.
- R5: Status bit 0 (level interrupt) follows the same comparison as `dma_burst` and drops by itself once reads bring the level back to the watermark or below.
- R6: The silence counter restarts on every accepted character and every data read, and advances on a `bit_tick` cycle only while the buffer is non-empty. Status bit 1 (timeout) sets on the 32nd such tick.
- R7: The timeout bit clears as soon as a read leaves the buffer empty, or on a write of 1 to bit 1 of the clear register. It does not set again until the counter has restarted.
- R8: Address 3 reads raw status {overrun, timeout, level} in bits [2:0]. Address 2 holds the mask in the same bit order. Address 4 reads raw AND mask, and `irq` is the OR of those masked bits.
- R9: A data read while the buffer is empty returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Deserializer offers a character |
| in_ready | output | 1 | Buffer has room; the character is accepted when both are high |
| in_data | input | 8 | Received data byte |
| in_flags | input | 4 | Error flags for the byte |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on a data read) |
| reg_wdata | input | 3 | Register write data |
| reg_rdata | output | 12 | Register read data, combinational |
| dma_single | output | 1 | Single-character DMA request |
| dma_burst | output | 1 | Burst DMA request |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is the timeout boundary while the counter keeps being restarted. The stimulus sends ticks while the buffer is empty, then a character, then a second character part-way through the count, then a read part-way through. Each of these must leave the timeout bit clear at the 31st tick after the last restart and set at the 32nd. A second hard case is clearing the timeout bit while the counter is saturated: the bit must stay clear under further ticks. Overrun is reached by filling all 32 entries through the stream port and offering one more character. The bench then checks that the discarded character never appears in the drained sequence.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
  localparam int CHAR_W  = 8;
  localparam int FLAG_W  = 4;
  localparam int ENTRY_W = CHAR_W + FLAG_W;
  localparam int CTRL_W  = 3;

  localparam logic [2:0] ADDR_DATA  = 3'd0;
  localparam logic [2:0] ADDR_LEVEL = 3'd1;
  localparam logic [2:0] ADDR_MASK  = 3'd2;
  localparam logic [2:0] ADDR_RAW   = 3'd3;
  localparam logic [2:0] ADDR_MSKD  = 3'd4;
  localparam logic [2:0] ADDR_CLEAR = 3'd5;

  localparam int BIT_LVL = 0;
  localparam int BIT_RTO = 1;
  localparam int BIT_OVR = 2;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [WIDTH-1:0]           wdata,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH):0]     fill,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (fill == CW'(DEPTH));
  assign empty = (fill == '0);
endmodule

// File: rtl/rxb_timeout.sv
module rxb_timeout #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic active,
  output logic expire
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;
  logic          step;

  assign step   = tick && active && (cnt != TW'(LIMIT));
  assign expire = !restart && step && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rxb_wmark.sv
module rxb_wmark #(
  parameter int DEPTH = 32
) (
  input  logic [2:0]               sel,
  input  logic [$clog2(DEPTH):0]   fill,
  output logic                     above
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] thr;

  always_comb begin
    case (sel)
      3'd0:    thr = CW'(DEPTH / 8);
      3'd1:    thr = CW'(DEPTH / 4);
      3'd2:    thr = CW'(DEPTH / 2);
      3'd3:    thr = CW'((DEPTH * 3) / 4);
      3'd4:    thr = CW'((DEPTH * 7) / 8);
      default: thr = CW'(DEPTH / 2);
    endcase
  end

  assign above = (fill > thr);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int RTO_BITS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CHAR_W-1:0]  in_data,
  input  logic [FLAG_W-1:0]  in_flags,
  input  logic               bit_tick,
  input  logic [2:0]         reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [CTRL_W-1:0]  reg_wdata,
  output logic [ENTRY_W-1:0] reg_rdata,
  output logic               dma_single,
  output logic               dma_burst,
  output logic               irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [ENTRY_W-1:0] head;
  logic [CW-1:0]      fill;
  logic               full, empty;
  logic               push, pop, drop, expire, above;
  logic               clr_wr;
  logic [CTRL_W-1:0]  level_sel, mask_q, raw, masked;
  logic               rto_q, ovr_q, rto_vis;

  assign in_ready = !full;
  assign push     = in_valid && !full;
  assign drop     = in_valid && full;
  assign pop      = reg_rd && (reg_addr == ADDR_DATA) && !empty;
  assign clr_wr   = reg_wr && (reg_addr == ADDR_CLEAR);

  rxb_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wdata({in_flags, in_data}), .head(head), .fill(fill),
    .full(full), .empty(empty)
  );

  rxb_timeout #(.LIMIT(RTO_BITS)) u_rto (
    .clk(clk), .rst_n(rst_n), .restart(push || pop),
    .tick(bit_tick), .active(!empty), .expire(expire)
  );

  rxb_wmark #(.DEPTH(DEPTH)) u_wmark (
    .sel(level_sel), .fill(fill), .above(above)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_sel <= '0;
      mask_q    <= '0;
      rto_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_LEVEL) level_sel <= reg_wdata;
      if (reg_wr && reg_addr == ADDR_MASK)  mask_q    <= reg_wdata;
      if (expire)                                      rto_q <= 1'b1;
      else if (empty || (clr_wr && reg_wdata[BIT_RTO])) rto_q <= 1'b0;
      if (drop)                                        ovr_q <= 1'b1;
      else if (clr_wr && reg_wdata[BIT_OVR])            ovr_q <= 1'b0;
    end
  end

  // timeout is only meaningful while data waits; hide it the moment the buffer empties
  assign rto_vis = rto_q && !empty;
  assign raw     = {ovr_q, rto_vis, above};
  assign masked  = raw & mask_q;
  assign irq     = |masked;

  assign dma_single = !empty;
  assign dma_burst  = above;

  always_comb begin
    case (reg_addr)
      ADDR_DATA:  reg_rdata = empty ? '0 : head;
      ADDR_LEVEL: reg_rdata = {{(ENTRY_W-CTRL_W){1'b0}}, level_sel};
      ADDR_MASK:  reg_rdata = {{(ENTRY_W-CTRL_W){1'b0}}, mask_q};
      ADDR_RAW:   reg_rdata = {{(ENTRY_W-CTRL_W){1'b0}}, raw};
      ADDR_MSKD:  reg_rdata = {{(ENTRY_W-CTRL_W){1'b0}}, masked};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic bit_tick,
  input logic dma_single,
  input logic dma_burst,
  input logic irq,
  input logic lvl_raw,
  input logic rto_raw,
  input logic ovr_raw
);
  assert_burst_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_burst |-> dma_single);

  assert_full_is_above_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> dma_burst);

  assert_drop_sets_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ovr_raw);

  assert_timeout_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rto_raw |-> dma_single);

  assert_timeout_rises_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rto_raw) |-> $past(bit_tick));

  assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (lvl_raw || rto_raw || ovr_raw));
endmodule

bind uart_rx_buffer rxb_checker u_rxb_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .bit_tick(bit_tick), .dma_single(dma_single), .dma_burst(dma_burst),
  .irq(irq), .lvl_raw(above), .rto_raw(rto_vis), .ovr_raw(ovr_q)
);

// File: tb/uart_rx_buffer_bench.sv
module uart_rx_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic [3:0]  in_flags = '0;
  logic        bit_tick = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic        dma_single, dma_burst, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [11:0] exp_q[$];
  logic [11:0] rd_val;
  event        rd_ev;

  always #5 clk = ~clk;

  uart_rx_buffer u_uart_rx_buffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_flags(in_flags), .bit_tick(bit_tick),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_single(dma_single), .dma_burst(dma_burst), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: offer one character, record it as expected if it was accepted
  task automatic push_char(logic [7:0] d, logic [3:0] f);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_flags = f;
    #1;
    if (in_ready) exp_q.push_back({f, d});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic reg_write(logic [2:0] a, logic [2:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [11:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic read_data();
    logic [11:0] v;
    reg_read(3'd0, v);
    rd_val = v;
    -> rd_ev;
    #0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  task automatic check_raw(string req, int exp);
    logic [11:0] v;
    reg_read(3'd3, v);
    check(req, int'(v), exp);
  endtask

  // monitor: every data read is compared with the scoreboard head
  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) check("R9 empty read", int'(rd_val), 0);
      else check("R1 order", int'(rd_val), int'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset ready", int'(in_ready), 1);
    check("R3 reset single", int'(dma_single), 0);
    check("R4 reset burst", int'(dma_burst), 0);
    check("R8 reset irq", int'(irq), 0);
    check_raw("R8 reset raw", 0);

    // watermark 4
    reg_write(3'd1, 3'd0);
    for (int i = 0; i < 4; i++) push_char(8'h10 + 8'(i), 4'(i));
    check("R3 single with data", int'(dma_single), 1);
    check("R4 burst at mark", int'(dma_burst), 0);
    push_char(8'h55, 4'h9);
    check("R4 burst above mark", int'(dma_burst), 1);
    check_raw("R5 level raw", 1);
    check("R8 irq masked off", int'(irq), 0);
    reg_write(3'd2, 3'b001);
    check("R8 irq level", int'(irq), 1);
    reg_read(3'd4, v);
    check("R8 masked status", int'(v), 1);
    read_data();
    read_data();
    check("R5 level autoclear", int'(dma_burst), 0);
    check_raw("R5 raw cleared", 0);

    // timeout, 3 held
    reg_write(3'd2, 3'b010);
    ticks(31);
    check_raw("R6 no timeout at 31", 0);
    ticks(1);
    check_raw("R6 timeout at 32", 2);
    check("R8 irq timeout", int'(irq), 1);
    reg_write(3'd5, 3'b010);
    check_raw("R7 w1c timeout", 0);
    ticks(5);
    check_raw("R7 stays clear saturated", 0);
    for (int i = 0; i < 3; i++) read_data();
    check("R3 single empty", int'(dma_single), 0);

    ticks(40);
    push_char(8'hA1, 4'h1);
    ticks(31);
    check_raw("R6 empty ticks not counted", 0);
    push_char(8'hA2, 4'h2);
    ticks(20);
    read_data();
    ticks(31);
    check_raw("R6 read restarts count", 0);
    ticks(1);
    check_raw("R6 timeout after restart", 2);
    read_data();
    check_raw("R7 cleared by emptying", 0);
    check("R7 irq after empty", int'(irq), 0);

    // overrun
    reg_write(3'd2, 3'b100);
    for (int i = 0; i < 32; i++) push_char(8'(i * 7), 4'(i));
    check("R2 full not ready", int'(in_ready), 0);
    push_char(8'hEE, 4'hF);
    check_raw("R2 overrun set", 5);
    check("R8 irq overrun", int'(irq), 1);
    for (int i = 0; i < 32; i++) read_data();
    check("R2 drained", int'(dma_single), 0);
    check_raw("R2 overrun sticky", 4);
    reg_write(3'd5, 3'b100);
    check_raw("R2 overrun cleared", 0);

    // watermark 28 and reserved select
    reg_write(3'd1, 3'd4);
    for (int i = 0; i < 28; i++) push_char(8'(i + 3), 4'h5);
    check("R4 burst at 28", int'(dma_burst), 0);
    push_char(8'h77, 4'h6);
    check("R4 burst at 29", int'(dma_burst), 1);
    reg_write(3'd1, 3'd7);
    reg_read(3'd1, v);
    check("R4 level readback", int'(v), 7);
    for (int i = 0; i < 12; i++) read_data();
    check("R4 reserved above 16", int'(dma_burst), 1);
    read_data();
    check("R4 reserved at 16", int'(dma_burst), 0);
    for (int i = 0; i < 16; i++) read_data();

    // empty read
    read_data();
    check("R9 still empty", int'(dma_single), 0);
    check("R9 ready", int'(in_ready), 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule